// File: doc/BRIEF.md
# Interrupt Delegation and Selection Unit

This block keeps the machine-level interrupt pending, enable and delegation registers of a hart. It gives software a supervisor view of the pending and enable registers, filtered by the delegation register, through a small CSR read/write port. Every cycle it combines the pending and enable state with the hart's current privilege level and the two global enable bits, one for machine level and one for supervisor level. It then reports whether an interrupt should be taken and which cause number wins.

Interrupts that are not delegated belong to machine level. Delegated ones belong to supervisor level. Both sets are judged in the same cycle. The surviving bits are merged, and the lowest-numbered bit wins. Hardware interrupt lines are sampled into the pending register once per cycle. Trap entry, vectoring and the timer comparator sit outside this block and use the `take_o`/`cause_o` pair.

There is no data stream here, so there is no valid/ready handshake. All pins are plain control and status. A CSR write takes effect at the next rising edge. A CSR read is combinational from the current register state.

Top module: `irq_deleg_sel`

## Requirements
- R1: After reset, the pending, enable and delegation registers are all zero, every CSR read returns zero, `take_o` is 0 and `cause_o` is 0.
- R2: Only bits 1, 5, 12 and 13 of the delegation register (address 0x303) are writable. A write leaves all other bits unchanged, and the register never changes without a write to it.
- R3: Only bits 1, 3, 5, 7, 12 and 13 of the machine enable register (address 0x304) are writable. The register changes only on a write to it or to the supervisor enable view.
- R4: A software write to the machine pending register (address 0x344) changes only bits 1, 3 and 5. Bits 7, 9, 10, 11, 12 and 13 take the values of the timer, supervisor-device, hypervisor-device, machine-device, coprocessor and host inputs from the previous cycle, whatever is written in that cycle.
- R5: A read of the supervisor pending view (0x144) returns pending AND delegation. A read of the supervisor enable view (0x104) returns enable AND delegation.
- R6: A write to a supervisor view replaces only the bits set in the delegation register and keeps the others. The merged value then passes through the machine register's own write mask.
- R7: With privilege encoded U=0, S=1, H=2, M=3, a pending-and-enabled interrupt that is not delegated is eligible when the privilege is below M, or when it is M and the machine global enable is 1.
- R8: A pending-and-enabled delegated interrupt is eligible when the privilege is U, or when it is S and the supervisor global enable is 1.
- R9: `take_o` is 1 exactly when any interrupt is eligible. `cause_o` is then the lowest eligible bit index. When no interrupt is eligible, `cause_o` is 0.
- R10: A read of any other CSR address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 2 | Current privilege (U=0, S=1, H=2, M=3) |
| m_gie_i | input | 1 | Machine-level global interrupt enable |
| s_gie_i | input | 1 | Supervisor-level global interrupt enable |
| mtimer_i | input | 1 | Machine timer line (pending bit 7) |
| sdev_i | input | 1 | Supervisor device line (bit 9) |
| hdev_i | input | 1 | Hypervisor device line (bit 10) |
| mdev_i | input | 1 | Machine device line (bit 11) |
| cop_i | input | 1 | Coprocessor line (bit 12) |
| host_i | input | 1 | Host line (bit 13) |
| csr_we_i | input | 1 | CSR write strobe, one cycle per write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data, combinational |
| take_o | output | 1 | An interrupt should be taken |
| cause_o | output | 4 | Cause number of the winning interrupt |

## Verification
The assertions assume that `priv_i` and the two global enables are driven to known values whenever reset is inactive. They also assume that the hardware lines and the CSR port change only between clock edges. The privilege value 2 is taken to be above S and below M. The stimulus drives every input at the falling edge and holds it for at least one full cycle, so each registered update sees stable values. The stimulus drives privilege only from the four legal 2-bit codes. The scoreboard predicts every read value, every take flag and every cause from a register model. That model follows the write masks and eligibility rules stated above.

// File: rtl/irq_deleg_pkg.sv
package irq_deleg_pkg;

  localparam int IRQ_W   = 14;
  localparam int CAUSE_W = $clog2(IRQ_W);

  typedef logic [IRQ_W-1:0] irq_vec_t;

  // bit positions of the interrupt lines
  localparam int B_SSW  = 1;
  localparam int B_MSW  = 3;
  localparam int B_STMR = 5;
  localparam int B_HTMR = 6;
  localparam int B_MTMR = 7;
  localparam int B_SDEV = 9;
  localparam int B_HDEV = 10;
  localparam int B_MDEV = 11;
  localparam int B_COP  = 12;
  localparam int B_HOST = 13;

  localparam irq_vec_t ONE = irq_vec_t'(1);

  localparam irq_vec_t DLG_WMASK   = (ONE << B_SSW) | (ONE << B_STMR) |
                                     (ONE << B_COP) | (ONE << B_HOST);
  localparam irq_vec_t ENAB_WMASK  = DLG_WMASK | (ONE << B_MSW) | (ONE << B_MTMR);
  localparam irq_vec_t PEND_SWMASK = (ONE << B_SSW) | (ONE << B_STMR) | (ONE << B_MSW);
  localparam irq_vec_t PEND_HWMASK = (ONE << B_MTMR) | (ONE << B_SDEV) | (ONE << B_HDEV) |
                                     (ONE << B_MDEV) | (ONE << B_COP)  | (ONE << B_HOST);

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_H = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MPEND,
    SEL_MENAB,
    SEL_DLG,
    SEL_SPEND,
    SEL_SENAB
  } csr_sel_e;

endpackage

// File: rtl/irq_csr_regs.sv
module irq_csr_regs
  import irq_deleg_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [11:0] A_MPEND = 12'h344,
  parameter logic [11:0] A_MENAB = 12'h304,
  parameter logic [11:0] A_DLG   = 12'h303,
  parameter logic [11:0] A_SPEND = 12'h144,
  parameter logic [11:0] A_SENAB = 12'h104
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [11:0]     addr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  irq_vec_t        hw_lines_i,
  output irq_vec_t        pend_o,
  output irq_vec_t        enab_o,
  output irq_vec_t        dlg_o,
  output logic [XLEN-1:0] rdata_o
);

  csr_sel_e sel;
  irq_vec_t pend_q, enab_q, dlg_q;
  irq_vec_t pend_d, enab_d, dlg_d;
  irq_vec_t pend_src, enab_src;
  irq_vec_t wv;
  logic     unused_whi;

  assign wv         = wdata_i[IRQ_W-1:0];
  assign unused_whi = ^wdata_i[XLEN-1:IRQ_W];

  always_comb begin
    if      (addr_i == A_MPEND) sel = SEL_MPEND;
    else if (addr_i == A_MENAB) sel = SEL_MENAB;
    else if (addr_i == A_DLG)   sel = SEL_DLG;
    else if (addr_i == A_SPEND) sel = SEL_SPEND;
    else if (addr_i == A_SENAB) sel = SEL_SENAB;
    else                        sel = SEL_NONE;
  end

  // supervisor views merge through the delegation register first
  always_comb begin
    pend_src = pend_q;
    enab_src = enab_q;
    if (sel == SEL_MPEND) pend_src = wv;
    if (sel == SEL_SPEND) pend_src = (pend_q & ~dlg_q) | (wv & dlg_q);
    if (sel == SEL_MENAB) enab_src = wv;
    if (sel == SEL_SENAB) enab_src = (enab_q & ~dlg_q) | (wv & dlg_q);
  end

  always_comb begin
    pend_d = pend_q;
    enab_d = enab_q;
    dlg_d  = dlg_q;
    if (we_i && (sel == SEL_MPEND || sel == SEL_SPEND))
      pend_d = (pend_q & ~PEND_SWMASK) | (pend_src & PEND_SWMASK);
    if (we_i && (sel == SEL_MENAB || sel == SEL_SENAB))
      enab_d = (enab_q & ~ENAB_WMASK) | (enab_src & ENAB_WMASK);
    if (we_i && sel == SEL_DLG)
      dlg_d = (dlg_q & ~DLG_WMASK) | (wv & DLG_WMASK);
    // hardware-owned pending bits follow the lines every cycle
    pend_d = (pend_d & ~PEND_HWMASK) | (hw_lines_i & PEND_HWMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      enab_q <= '0;
      dlg_q  <= '0;
    end else begin
      pend_q <= pend_d;
      enab_q <= enab_d;
      dlg_q  <= dlg_d;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_MPEND: rdata_o = XLEN'(pend_q);
      SEL_MENAB: rdata_o = XLEN'(enab_q);
      SEL_DLG:   rdata_o = XLEN'(dlg_q);
      SEL_SPEND: rdata_o = XLEN'(pend_q & dlg_q);
      SEL_SENAB: rdata_o = XLEN'(enab_q & dlg_q);
      default:   rdata_o = '0;
    endcase
  end

  assign pend_o = pend_q;
  assign enab_o = enab_q;
  assign dlg_o  = dlg_q;

  // R2
  dlg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && sel == SEL_DLG) |=> $stable(dlg_q));

  // R3
  enab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && (sel == SEL_MENAB || sel == SEL_SENAB)) |=> $stable(enab_q));

  // R4
  hw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & PEND_HWMASK) == ($past(hw_lines_i) & PEND_HWMASK)));

  // R6
  sview_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel == SEL_SPEND) |=>
      ((pend_q & ~$past(dlg_q) & PEND_SWMASK) ==
       ($past(pend_q) & ~$past(dlg_q) & PEND_SWMASK)));

endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_deleg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic [1:0] priv_i,
  input  logic     m_gie_i,
  input  logic     s_gie_i,
  input  irq_vec_t pend_i,
  input  irq_vec_t enab_i,
  input  irq_vec_t dlg_i,
  output irq_vec_t elig_o
);

  logic     m_ok, s_ok;
  irq_vec_t armed;

  assign armed = pend_i & enab_i;
  assign m_ok  = (priv_i != PRIV_M) || m_gie_i;
  assign s_ok  = (priv_i == PRIV_U) || (priv_i == PRIV_S && s_gie_i);

  assign elig_o = (armed & ~dlg_i & {IRQ_W{m_ok}}) |
                  (armed &  dlg_i & {IRQ_W{s_ok}});

  // R7
  m_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == PRIV_M && !m_gie_i) |-> ((elig_o & ~dlg_i) == '0));

  // R8
  s_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == PRIV_M || priv_i == PRIV_H) |-> ((elig_o & dlg_i) == '0));

  // R7
  elig_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((elig_o & ~(pend_i & enab_i)) == '0));

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick
  import irq_deleg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  irq_vec_t           vec_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o
);

  irq_vec_t first;

  for (genvar g = 0; g < IRQ_W; g++) begin : g_scan
    localparam irq_vec_t LOWER = (ONE << g) - ONE;
    assign first[g] = vec_i[g] & ~(|(vec_i & LOWER));
  end

  always_comb begin
    cause_o = '0;
    for (int i = 0; i < IRQ_W; i++)
      if (first[i]) cause_o = cause_o | CAUSE_W'(i);
  end

  assign take_o = |vec_i;

  // R9
  win_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> vec_i[cause_o]);

  // R9
  win_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((vec_i & ((ONE << cause_o) - ONE)) == '0));

  // R9
  idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (cause_o == '0));

endmodule

// File: rtl/irq_deleg_sel.sv
module irq_deleg_sel
  import irq_deleg_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [11:0] A_MPEND = 12'h344,
  parameter logic [11:0] A_MENAB = 12'h304,
  parameter logic [11:0] A_DLG   = 12'h303,
  parameter logic [11:0] A_SPEND = 12'h144,
  parameter logic [11:0] A_SENAB = 12'h104
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  input  logic               mtimer_i,
  input  logic               sdev_i,
  input  logic               hdev_i,
  input  logic               mdev_i,
  input  logic               cop_i,
  input  logic               host_i,
  input  logic               csr_we_i,
  input  logic [11:0]        csr_addr_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o
);

  irq_vec_t hw_lines, pend, enab, dlg, elig;

  always_comb begin
    hw_lines         = '0;
    hw_lines[B_MTMR] = mtimer_i;
    hw_lines[B_SDEV] = sdev_i;
    hw_lines[B_HDEV] = hdev_i;
    hw_lines[B_MDEV] = mdev_i;
    hw_lines[B_COP]  = cop_i;
    hw_lines[B_HOST] = host_i;
  end

  irq_csr_regs #(
    .XLEN(XLEN), .A_MPEND(A_MPEND), .A_MENAB(A_MENAB), .A_DLG(A_DLG),
    .A_SPEND(A_SPEND), .A_SENAB(A_SENAB)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .we_i(csr_we_i), .addr_i(csr_addr_i),
    .wdata_i(csr_wdata_i), .hw_lines_i(hw_lines), .pend_o(pend),
    .enab_o(enab), .dlg_o(dlg), .rdata_o(csr_rdata_o)
  );

  irq_level_gate gate_i (
    .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .m_gie_i(m_gie_i),
    .s_gie_i(s_gie_i), .pend_i(pend), .enab_i(enab), .dlg_i(dlg),
    .elig_o(elig)
  );

  irq_lowest_pick pick_i (
    .clk(clk), .rst_n(rst_n), .vec_i(elig), .take_o(take_o), .cause_o(cause_o)
  );

  // R8
  no_dlg_in_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && priv_i == PRIV_M) |-> !dlg[cause_o]);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!take_o && pend == '0 && enab == '0 && dlg == '0) || !rst_n);

endmodule

// File: tb/irq_deleg_sel_tb_top.sv
module irq_deleg_sel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_MPEND = 12'h344, A_MENAB = 12'h304, A_DLG = 12'h303,
                          A_SPEND = 12'h144, A_SENAB = 12'h104, A_OTHER = 12'h000;
  localparam logic [13:0] DLG_M = 14'h3022, ENAB_M = 14'h30AA,
                          SW_M = 14'h002A, HW_M = 14'h3E80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] priv = 2'd3;
  logic m_gie = 1'b0, s_gie = 1'b0;
  logic mtimer = 0, sdev = 0, hdev = 0, mdev = 0, cop = 0, host = 0;
  logic csr_we = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic take;
  logic [3:0] cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_deleg_sel dut_i (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .m_gie_i(m_gie), .s_gie_i(s_gie),
    .mtimer_i(mtimer), .sdev_i(sdev), .hdev_i(hdev), .mdev_i(mdev),
    .cop_i(cop), .host_i(host), .csr_we_i(csr_we), .csr_addr_i(csr_addr),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata), .take_o(take), .cause_o(cause)
  );

  typedef struct {
    logic [31:0] rd;
    logic        tk;
    logic [3:0]  cs;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  event obs_ev;
  int   checks = 0, errors = 0;
  logic [13:0] m_pend = '0, m_enab = '0, m_dlg = '0;

  function automatic logic [31:0] model_rd(logic [11:0] a);
    case (a)
      A_MPEND: return 32'(m_pend);
      A_MENAB: return 32'(m_enab);
      A_DLG:   return 32'(m_dlg);
      A_SPEND: return 32'(m_pend & m_dlg);
      A_SENAB: return 32'(m_enab & m_dlg);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [13:0] model_elig();
    logic mok = (priv != 2'd3) || m_gie;
    logic sok = (priv == 2'd0) || (priv == 2'd1 && s_gie);
    logic [13:0] pe = m_pend & m_enab;
    return (pe & ~m_dlg & {14{mok}}) | (pe & m_dlg & {14{sok}});
  endfunction

  function automatic logic [3:0] model_cause(logic [13:0] e);
    for (int i = 0; i < 14; i++) if (e[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic observe(logic [11:0] a, string tag);
    exp_t it;
    logic [13:0] e;
    csr_addr = a;
    e = model_elig();
    it.rd = model_rd(a); it.tk = |e; it.cs = model_cause(e); it.tag = tag;
    sb_q.push_back(it);
    -> obs_ev;
    #2;
  endtask

  always begin
    exp_t it;
    @(obs_ev);
    #1;
    it = sb_q.pop_front();
    checks += 3;
    if (csr_rdata !== it.rd) begin
      errors++; $display("FAIL %s: rdata got %h exp %h", it.tag, csr_rdata, it.rd);
    end
    if (take !== it.tk) begin
      errors++; $display("FAIL %s: take got %b exp %b", it.tag, take, it.tk);
    end
    if (cause !== it.cs) begin
      errors++; $display("FAIL %s: cause got %0d exp %0d", it.tag, cause, it.cs);
    end
  end

  task automatic csr_write(logic [11:0] a, logic [31:0] d);
    logic [13:0] v = d[13:0];
    logic [13:0] src;
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
    case (a)
      A_DLG:   m_dlg  = (m_dlg & ~DLG_M) | (v & DLG_M);
      A_MENAB: m_enab = (m_enab & ~ENAB_M) | (v & ENAB_M);
      A_SENAB: begin
        src = (m_enab & ~m_dlg) | (v & m_dlg);
        m_enab = (m_enab & ~ENAB_M) | (src & ENAB_M);
      end
      A_MPEND: m_pend = (m_pend & ~SW_M) | (v & SW_M);
      A_SPEND: begin
        src = (m_pend & ~m_dlg) | (v & m_dlg);
        m_pend = (m_pend & ~SW_M) | (src & SW_M);
      end
      default: ;
    endcase
  endtask

  task automatic set_hw(logic [13:0] v);
    @(negedge clk);
    mtimer = v[7]; sdev = v[9]; hdev = v[10]; mdev = v[11]; cop = v[12]; host = v[13];
    @(negedge clk);
    m_pend = (m_pend & ~HW_M) | (v & HW_M);
  endtask

  task automatic sweep(string name);
    for (int p = 0; p < 4; p++)
      for (int mg = 0; mg < 2; mg++)
        for (int sg = 0; sg < 2; sg++) begin
          @(negedge clk);
          priv = 2'(p); m_gie = mg[0]; s_gie = sg[0];
          observe(A_MPEND, $sformatf("R7/R8/R9 %s priv=%0d mg=%0d sg=%0d", name, p, mg, sg));
        end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R10 unmapped address
    observe(A_MPEND, "R1 pend"); observe(A_MENAB, "R1 enab");
    observe(A_DLG, "R1 dlg");    observe(A_SPEND, "R1 spend");
    observe(A_SENAB, "R1 senab"); observe(A_OTHER, "R10 unmapped");

    // R2 delegation mask
    csr_write(A_DLG, 32'hFFFF_FFFF); observe(A_DLG, "R2 all ones");
    csr_write(A_DLG, 32'h0);         observe(A_DLG, "R2 cleared");
    csr_write(A_DLG, 32'hFFFF_FFFF);
    // R3 enable mask
    csr_write(A_MENAB, 32'hFFFF_FFFF); observe(A_MENAB, "R3 all ones");
    // R4 software and hardware pending bits
    csr_write(A_MPEND, 32'hFFFF_FFFF); observe(A_MPEND, "R4 sw write");
    set_hw(14'h3E80);                  observe(A_MPEND, "R4 hw lines");
    csr_write(A_MPEND, 32'h0);         observe(A_MPEND, "R4 write vs hw");
    set_hw(14'h0);                     observe(A_MPEND, "R4 hw drop");
    csr_write(A_MPEND, 32'h2A);
    set_hw(14'h3080);
    // R5 supervisor views
    observe(A_SPEND, "R5 spend"); observe(A_SENAB, "R5 senab");
    // R6 supervisor view writes
    csr_write(A_SPEND, 32'h0);  observe(A_MPEND, "R6 spend clear");
    csr_write(A_SENAB, 32'h0);  observe(A_MENAB, "R6 senab clear");
    csr_write(A_SENAB, 32'hFFFF_FFFF); observe(A_MENAB, "R6 senab set");
    csr_write(A_SPEND, 32'hFFFF_FFFF); observe(A_MPEND, "R6 spend set");
    csr_write(A_DLG, 32'h0);
    csr_write(A_MPEND, 32'h0);
    csr_write(A_SPEND, 32'hFFFF_FFFF); observe(A_MPEND, "R6 no delegation");
    csr_write(A_SENAB, 32'h0);         observe(A_MENAB, "R6 senab no delegation");
    // R7 R8 R9 selection
    csr_write(A_DLG, 32'hFFFF_FFFF);
    csr_write(A_MPEND, 32'h2A);
    sweep("mixed");
    csr_write(A_MPEND, 32'h0);
    set_hw(14'h3000);
    sweep("delegated only");
    csr_write(A_DLG, 32'h0);
    csr_write(A_MPEND, 32'h2A);
    set_hw(14'h0080);
    sweep("machine only");
    csr_write(A_MENAB, 32'h0);
    sweep("none enabled");

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule